// File: doc/BRIEF.md
# Retention Voltage Calibration Controller

This controller searches for the lowest standby supply code at which an on-chip SRAM still keeps its contents. It drives a digital setting code to an external DC-DC converter. After each change it waits a programmable settle interval and then fires a strobe that starts one built-in integrity test of the array. When the test reports back, the controller decides its next move. A pass lowers the code by one step. The first fail lifts the code by two steps for a re-check. Further fails while climbing lift the code by one step at a time. The first pass after a fail ends the search.

The winning code is held on a result output, so it can be used as the array supply while the chip is in standby. Because the search runs on the die, the result follows local threshold spread and temperature. If the array fails at the top code, the controller flags an error instead of giving a result. The converter, the sensing path and the array are all outside the block.

Top module: `rvc_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `err`, `test_go` are 0, `ret_code` is 0 and `vcode` is the top code (all ones).
- R2: A `start` seen while idle sets `busy`, sets `vcode` to the top code, and clears `err` and `ret_code`, all on the next clock edge.
- R3: Every `test_go` is a one-cycle pulse. It rises exactly `settle_len`+1 cycles after the edge on which `vcode` last changed or the run began. It is never high while `busy` is 0.
- R4: A passing test before any fail lowers `vcode` by exactly one and starts another settle and test.
- R5: The first failing test raises `vcode` by two, saturating at the top code, and starts a re-check.
- R6: A pass after a fail copies `vcode` into `ret_code`, pulses `done` for one cycle and drops `busy`. Against an array that holds data at codes of at least T, the result is min(T+1, top) for T ≥ 1.
- R7: A pass at code 0 during the descent ends the run with `ret_code` = 0.
- R8: Each failing re-check below the top code raises `vcode` by one and tests again.
- R9: A fail at the top code ends the run with `err` = 1, a one-cycle `done` pulse and `ret_code` = 0.
- R10: `start` is ignored while `busy` is 1, including the cycle in which the final result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a calibration run |
| settle_len | input | SETTLE_W | Settle cycles minus one to wait after a code change |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Last run failed at the top code |
| vcode | output | CODE_W | Supply setting driven to the converter |
| test_go | output | 1 | Start strobe for one integrity test |
| test_done | input | 1 | Test result valid this cycle |
| test_pass | input | 1 | Test result, 1 for pass |
| ret_code | output | CODE_W | Saved retention code |

## Verification
Two events can meet in one cycle: the closing test result and a fresh `start` request. The bench raises `start` in the very cycle that carries the final `test_done`. It expects that request to be lost, so the result stays intact and the block stays idle. It then raises `start` again in the cycle where `done` is high. That request must be taken and must clear the old result on the following edge. A model array whose failure threshold can shift after the first fail drives the climbing path and the error path.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SETTLE = 2'd1,
    S_WAIT   = 2'd2
  } rvc_state_t;
endpackage

// File: rtl/rvc_settle_timer.sv
module rvc_settle_timer #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [SETTLE_W-1:0] len,
  output logic                expired
);
  logic [SETTLE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R3: a load always restarts the count from the programmed length
  p_load_len_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt == $past(len));
endmodule

// File: rtl/rvc_code_step.sv
module rvc_code_step #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] dn1,
  output logic [CODE_W-1:0] up1,
  output logic [CODE_W-1:0] up2,
  output logic              at_min,
  output logic              at_max
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  always_comb begin
    at_min = (code == '0);
    at_max = (code == TOP);
    dn1    = at_min ? code : code - 1'b1;
    up1    = at_max ? code : code + 1'b1;
    up2    = (code >= TOP - 1'b1) ? TOP : code + CODE_W'(2);
  end
endmodule

// File: rtl/rvc_ctrl.sv
module rvc_ctrl
  import rvc_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic [CODE_W-1:0]   vcode,
  output logic                test_go,
  input  logic                test_done,
  input  logic                test_pass,
  output logic [CODE_W-1:0]   ret_code
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  rvc_state_t        state;
  logic              climb;
  logic              tmr_load, tmr_exp;
  logic              run_begin, retest, fin_ok, fin_err;
  logic [CODE_W-1:0] nxt_code, dn1, up1, up2;
  logic              at_min, at_max;

  rvc_code_step #(.CODE_W(CODE_W)) u_step (
    .code(vcode), .dn1(dn1), .up1(up1), .up2(up2),
    .at_min(at_min), .at_max(at_max)
  );

  rvc_settle_timer #(.SETTLE_W(SETTLE_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .len(settle_len),
    .expired(tmr_exp)
  );

  always_comb begin
    nxt_code  = vcode;
    retest    = 1'b0;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    run_begin = (state == S_IDLE) && start;
    if (state == S_WAIT && test_done) begin
      if (test_pass) begin
        if (!climb && !at_min) begin
          nxt_code = dn1;
          retest   = 1'b1;
        end else begin
          fin_ok = 1'b1;
        end
      end else if (at_max) begin
        fin_err = 1'b1;
      end else begin
        nxt_code = climb ? up1 : up2;
        retest   = 1'b1;
      end
    end
    tmr_load = run_begin || retest;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      vcode    <= TOP;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      test_go  <= 1'b0;
      climb    <= 1'b0;
      ret_code <= '0;
    end else begin
      done    <= 1'b0;
      test_go <= 1'b0;
      case (state)
        S_IDLE: begin
          if (run_begin) begin
            vcode    <= TOP;
            busy     <= 1'b1;
            err      <= 1'b0;
            ret_code <= '0;
            climb    <= 1'b0;
            state    <= S_SETTLE;
          end
        end
        S_SETTLE: begin
          if (tmr_exp) begin
            test_go <= 1'b1;
            state   <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (fin_ok) begin
            ret_code <= vcode;
            done     <= 1'b1;
            busy     <= 1'b0;
            state    <= S_IDLE;
          end else if (fin_err) begin
            err   <= 1'b1;
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else if (retest) begin
            vcode <= nxt_code;
            climb <= climb | ~test_pass;
            state <= S_SETTLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3: strobe is a single cycle wide
  p_go_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    test_go |=> !test_go);
  // R3: no strobe on the cycle a new code appears
  p_go_not_on_change_r3: assert property (@(posedge clk) disable iff (rst)
    (vcode != $past(vcode)) |-> !test_go);
  // R3: quiet when idle
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !test_go);
  // R4: descent moves down by exactly one
  p_descend_one_r4: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && test_done && test_pass && !climb && vcode != '0)
      |=> (int'(vcode) == int'($past(vcode)) - 1));
  // R5: first fail lifts by two, saturated
  p_raise_two_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && test_done && !test_pass && !climb && vcode != TOP)
      |=> (int'(vcode) == ((int'($past(vcode)) + 2 > int'(TOP)) ?
                            int'(TOP) : int'($past(vcode)) + 2)));
  // R6: completion pulse is a single cycle wide
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: error only raised from the top code
  p_err_top_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> (vcode == TOP));
  // R10: a request during a run disturbs nothing
  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !test_done) |=> busy && $stable(vcode) && $stable(ret_code));
endmodule

// File: tb/rvc_ctrl_tb.sv
`timescale 1ns/1ps
module rvc_ctrl_tb;
  localparam int CW  = 4;
  localparam int SW  = 4;
  localparam int TOP = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [SW-1:0] settle_len = '0;
  logic          busy, done, err, test_go;
  logic [CW-1:0] vcode, ret_code;
  logic          test_done = 1'b0;
  logic          test_pass = 1'b0;

  int checks = 0;
  int failures = 0;

  // array model and monitors
  int thr = 0;
  int drift = 0;
  bit drifted = 0;
  int lat = 0;
  int go_cnt = 0;
  int settle_bad = 0;
  bit fail_seen = 0;
  int ff_code = -1;
  int after_code = -1;
  bit start_on_final = 0;
  int gap = 0;
  logic [CW-1:0] prev_code = '1;
  logic prev_busy = 1'b0;

  always #2.5 clk = ~clk;

  rvc_ctrl #(.CODE_W(CW), .SETTLE_W(SW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .settle_len(settle_len),
    .busy(busy), .done(done), .err(err), .vcode(vcode),
    .test_go(test_go), .test_done(test_done), .test_pass(test_pass),
    .ret_code(ret_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // settle-gap monitor (R3)
  always @(negedge clk) begin
    if (vcode != prev_code || (busy && !prev_busy)) gap = 0;
    else gap = gap + 1;
    if (test_go) begin
      go_cnt = go_cnt + 1;
      if (gap != int'(settle_len) + 1) settle_bad = settle_bad + 1;
    end
    if (test_go && !busy) settle_bad = settle_bad + 1;
    prev_code = vcode;
    prev_busy = busy;
  end

  // behavioural integrity test responder
  initial begin
    forever begin
      @(negedge clk);
      if (test_go) begin
        repeat (lat) @(negedge clk);
        test_pass = (int'(vcode) >= thr);
        test_done = 1'b1;
        if (fail_seen && after_code < 0) after_code = int'(vcode);
        if (!test_pass && !fail_seen) begin
          fail_seen = 1;
          ff_code = int'(vcode);
        end
        if (!test_pass && drift > 0 && !drifted) begin
          thr = thr + drift;
          drifted = 1;
        end
        if (start_on_final && test_pass && fail_seen) start = 1'b1;
        @(negedge clk);
        test_done = 1'b0;
        if (start_on_final) begin
          start = 1'b0;
          start_on_final = 0;
        end
      end
    end
  end

  task automatic prep(input int t, input int d, input int l, input int s);
    thr = t; drift = d; drifted = 0; lat = l;
    settle_len = SW'(s);
    go_cnt = 0; settle_bad = 0;
    fail_seen = 0; ff_code = -1; after_code = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 0;
    while (n < 5000) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
      n++;
    end
  endtask

  task automatic t_reset();
    check(!busy && !done && !err && !test_go, "R1 idle outputs", int'({busy,done,err,test_go}), 0);
    check(ret_code == '0, "R1 ret_code", int'(ret_code), 0);
    check(int'(vcode) == TOP, "R1 vcode", int'(vcode), TOP);
  endtask

  task automatic t_sweep();
    bit ok;
    int bad_res = 0, bad_cnt = 0, bad_r5 = 0, bad_set = 0, exp_r, exp_n;
    for (int t = 0; t <= TOP; t++) begin
      prep(t, 0, t % 2, t % 3);
      pulse_start();
      wait_done(ok);
      exp_r = (t == 0) ? 0 : ((t + 1 > TOP) ? TOP : t + 1);
      exp_n = (t == 0) ? TOP + 1 : TOP - t + 3;
      if (t == 0) check(ok && ret_code == '0 && !err, "R7 pass at code zero", int'(ret_code), 0);
      else if (!ok || int'(ret_code) != exp_r || err) begin
        bad_res++;
        $display("FAIL R6 thr=%0d actual=%0d expected=%0d", t, ret_code, exp_r);
      end
      if (go_cnt != exp_n) begin
        bad_cnt++;
        $display("FAIL R4 thr=%0d tests actual=%0d expected=%0d", t, go_cnt, exp_n);
      end
      if (t > 0 && after_code != ((ff_code + 2 > TOP) ? TOP : ff_code + 2)) begin
        bad_r5++;
        $display("FAIL R5 thr=%0d recheck actual=%0d expected=%0d", t, after_code,
                 (ff_code + 2 > TOP) ? TOP : ff_code + 2);
      end
      bad_set += settle_bad;
      @(negedge clk);
      check(!done && !busy, "R6 done one cycle, idle after", int'({done,busy}), 0);
    end
    checks += 3;
    if (bad_res != 0) failures++;
    if (bad_cnt != 0) failures++;
    if (bad_r5 != 0) failures++;
    check(bad_set == 0, "R3 settle gap", bad_set, 0);
  endtask

  task automatic t_climb();
    bit ok;
    prep(10, 3, 1, 2);
    pulse_start();
    wait_done(ok);
    check(ok && int'(ret_code) == 13 && !err, "R8 climb by one result", int'(ret_code), 13);
    check(go_cnt == 10, "R8 climb test count", go_cnt, 10);
    check(settle_bad == 0, "R3 settle gap climb", settle_bad, 0);
  endtask

  task automatic t_error();
    bit ok;
    prep(TOP + 1, 0, 0, 1);
    pulse_start();
    wait_done(ok);
    check(ok && err && ret_code == '0, "R9 fail at top", int'({err, ret_code}), 1 << CW);
    check(go_cnt == 1, "R9 single test", go_cnt, 1);
    prep(12, 10, 0, 0);
    pulse_start();
    wait_done(ok);
    check(ok && err && ret_code == '0, "R9 climb reaches top", int'({err, ret_code}), 1 << CW);
    @(negedge clk);
    check(!done, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_busy_start();
    bit ok;
    prep(5, 0, 0, 1);
    pulse_start();
    repeat (15) @(negedge clk);
    start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(ok && int'(ret_code) == 6, "R10 start during run ignored", int'(ret_code), 6);
    check(go_cnt == TOP - 5 + 3, "R10 no restart test count", go_cnt, TOP - 5 + 3);
    // start arriving with the final result
    prep(5, 0, 0, 1);
    start_on_final = 1;
    pulse_start();
    wait_done(ok);
    repeat (3) @(negedge clk);
    check(ok && !busy && int'(ret_code) == 6, "R10 start with final result ignored",
          int'({busy, ret_code}), 6);
    // start during the done pulse is accepted
    prep(5, 0, 0, 1);
    pulse_start();
    wait_done(ok);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && ret_code == '0 && int'(vcode) == TOP && !err, "R2 restart clears result",
          int'({busy, ret_code}), 1 << CW);
    wait_done(ok);
    check(ok && int'(ret_code) == 6, "R2 restart completes", int'(ret_code), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_climb();
    t_error();
    t_busy_start();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule